// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block holds the program counter of a 32-bit integer core and decides, once per retiring control-flow slot, where fetch goes next. It receives the two register operands, an already decoded and sign-extended immediate, the three-bit condition code and one flag each for a conditional branch, a PC-relative jump and a register-relative jump. From these it evaluates the branch condition, builds the candidate target and reports whether the sequential path is left.

Jumps also produce the return address (the current PC plus 4) together with a write enable for the destination register. The enable stays low when the destination index is zero. A taken target that is not word aligned is refused: a flag is raised and the PC keeps its value. The surrounding pipeline then handles the fault.

Top module: `branch_npc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pc` equals the `RESET_VEC` parameter (default 0x0000_1000).
- R2: With `is_branch` set, `cond` selects the test of `rs1_val` against `rs2_val`: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. `redirect` is high in a `step` cycle exactly when the selected test holds.
- R3: A taken branch loads `pc` with the old `pc` plus `imm` at the next clock edge, with bit 0 of `imm` treated as zero.
- R4: When `step` is high and nothing is taken, `pc` advances by 4 at the next edge.
- R5: `is_jal` always redirects to `pc` plus `imm` (bit 0 treated as zero).
- R6: `is_jalr` always redirects to `rs1_val` plus `imm`, with bit 0 of the sum cleared.
- R7: Condition codes 010 and 011 never cause a redirect, so `pc` advances by 4.
- R8: `link_we` is high in a `step` cycle for a jump whose `rd_idx` is not zero and whose target is aligned. `link_val` always equals `pc` plus 4.
- R9: A taken target with bit 1 set raises `misalign`, drops `link_we`, and leaves `pc` unchanged.
- R10: With `step` low, `pc` holds and `redirect`, `misalign` and `link_we` are low.
- R11: When more than one flag is set, the register-relative jump wins over the PC-relative jump, and the PC-relative jump wins over the branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | A control-flow slot retires this cycle |
| is_branch | input | 1 | Conditional branch |
| is_jal | input | 1 | PC-relative jump |
| is_jalr | input | 1 | Register-relative jump |
| cond | input | 3 | Branch condition code |
| rs1_val | input | XLEN | First operand / jump base |
| rs2_val | input | XLEN | Second operand |
| imm | input | XLEN | Sign-extended immediate |
| rd_idx | input | 5 | Destination register index |
| pc | output | XLEN | Current program counter |
| next_pc | output | XLEN | Value `pc` takes at the next edge when `step` is high |
| redirect | output | 1 | Sequential path left |
| link_val | output | XLEN | Return address |
| link_we | output | 1 | Return address write enable |
| misalign | output | 1 | Taken target not word aligned |

## Verification
The PC register is the only state, so a wrong PC shows up on `pc` and `link_val` in the cycle right after the faulty edge. From then on every later target is offset by the same error. The bench therefore tracks its own expected PC across a chain of dependent steps. A single bad update or a missed hold, for example on a misaligned target, is then visible at the next sample and in all later ones. Wrong condition decoding shows at once on `redirect`, before any edge.

// File: rtl/branch_npc.sv
module branch_npc #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            is_branch,
  input  logic            is_jal,
  input  logic            is_jalr,
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm,
  input  logic [4:0]      rd_idx,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect,
  output logic [XLEN-1:0] link_val,
  output logic            link_we,
  output logic            misalign
);
  localparam logic [XLEN-1:0] EVEN_MASK = ~{{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] STRIDE    = XLEN'(4);

  logic            eq, lt_s, lt_u, cond_ok, taken;
  logic [XLEN-1:0] target, seq_pc;

  assign eq   = rs1_val == rs2_val;
  assign lt_s = $signed(rs1_val) < $signed(rs2_val);
  assign lt_u = rs1_val < rs2_val;

  always_comb begin
    case (cond)
      3'b000:  cond_ok = eq;
      3'b001:  cond_ok = !eq;
      3'b100:  cond_ok = lt_s;
      3'b101:  cond_ok = !lt_s;
      3'b110:  cond_ok = lt_u;
      3'b111:  cond_ok = !lt_u;
      default: cond_ok = 1'b0;
    endcase
  end

  assign seq_pc   = pc + STRIDE;
  assign target   = is_jalr ? ((rs1_val + imm) & EVEN_MASK) : (pc + (imm & EVEN_MASK));
  assign taken    = is_jalr | is_jal | (is_branch & cond_ok);
  assign redirect = step & taken;
  assign misalign = redirect & target[1];
  assign next_pc  = misalign ? pc : (redirect ? target : seq_pc);
  assign link_val = seq_pc;
  assign link_we  = step & (is_jal | is_jalr) & (rd_idx != 5'd0) & !misalign;

  always_ff @(posedge clk) begin
    if (!rst_n)    pc <= RESET_VEC;
    else if (step) pc <= next_pc;
  end
endmodule

module branch_npc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic            is_branch,
  input logic            is_jal,
  input logic            is_jalr,
  input logic [2:0]      cond,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] next_pc,
  input logic            redirect,
  input logic            link_we,
  input logic            misalign
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> !redirect && !misalign && !link_we); // R10
  AST_STEP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pc == $past(next_pc)); // R3
  AST_SEQ_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    step && !redirect |=> pc == $past(pc) + XLEN'(4)); // R4
  AST_MIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    step && misalign |=> $stable(pc)); // R9
  AST_MIS_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> redirect && !link_we); // R9
  AST_BAD_COND: assert property (@(posedge clk) disable iff (!rst_n)
    step && is_branch && !is_jal && !is_jalr && cond[2:1] == 2'b01 |-> !redirect); // R7
  AST_WORD_PC: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00); // R9
endmodule

bind branch_npc branch_npc_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .is_branch(is_branch), .is_jal(is_jal),
  .is_jalr(is_jalr), .cond(cond), .pc(pc), .next_pc(next_pc), .redirect(redirect),
  .link_we(link_we), .misalign(misalign)
);

// File: tb/branch_npc_test.sv
module branch_npc_test;
  localparam logic [31:0] RV = 32'h0000_1000;

  typedef struct packed {
    logic [1:0]  kind;   // 0 branch, 1 jal, 2 jalr
    logic [2:0]  f3;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] im;
    logic [4:0]  rd;
    logic        tk;
    logic        ms;
    logic        lw;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{2'd0, 3'b000, 32'd5,        32'd5, 32'd16,        5'd0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 3'b000, 32'd5,        32'd6, 32'd16,        5'd0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 3'b001, 32'd5,        32'd6, 32'hFFFF_FFF8, 5'd0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 3'b001, 32'd7,        32'd7, 32'd8,         5'd0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 3'b100, 32'hFFFF_FFFF,32'd1, 32'd20,        5'd0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 3'b110, 32'hFFFF_FFFF,32'd1, 32'd20,        5'd0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 3'b101, 32'hFFFF_FFFF,32'd1, 32'd20,        5'd0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 3'b111, 32'hFFFF_FFFF,32'd1, 32'd8,         5'd0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 3'b101, 32'd9,        32'd9, 32'd4,         5'd0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 3'b110, 32'd1,        32'd2, 32'd12,        5'd0, 1'b1, 1'b0, 1'b0},
    '{2'd0, 3'b010, 32'd3,        32'd3, 32'd16,        5'd0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 3'b011, 32'd3,        32'd9, 32'd16,        5'd0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 3'b000, 32'd0,        32'd0, 32'h100,       5'd1, 1'b1, 1'b0, 1'b1},
    '{2'd1, 3'b000, 32'd0,        32'd0, 32'hFFFF_FFFC, 5'd0, 1'b1, 1'b0, 1'b0},
    '{2'd1, 3'b000, 32'd0,        32'd0, 32'h101,       5'd3, 1'b1, 1'b0, 1'b1},
    '{2'd2, 3'b000, 32'h2003,     32'd0, 32'd1,         5'd5, 1'b1, 1'b0, 1'b1},
    '{2'd2, 3'b000, 32'h3001,     32'd0, 32'd1,         5'd5, 1'b1, 1'b1, 1'b0},
    '{2'd0, 3'b000, 32'd4,        32'd4, 32'd6,         5'd0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0, step = 0, is_branch = 0, is_jal = 0, is_jalr = 0;
  logic [2:0]  cond = 0;
  logic [31:0] rs1_val = 0, rs2_val = 0, imm = 0;
  logic [4:0]  rd_idx = 0;
  logic [31:0] pc, next_pc, link_val;
  logic        redirect, link_we, misalign;
  int tests = 0, fails = 0;
  logic [31:0] exp_pc;
  logic        done = 0;

  always #10 clk = ~clk;

  branch_npc #(.XLEN(32), .RESET_VEC(RV)) uut (
    .clk(clk), .rst_n(rst_n), .step(step), .is_branch(is_branch), .is_jal(is_jal),
    .is_jalr(is_jalr), .cond(cond), .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm),
    .rd_idx(rd_idx), .pc(pc), .next_pc(next_pc), .redirect(redirect),
    .link_val(link_val), .link_we(link_we), .misalign(misalign)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] tgt(input vec_t v, input logic [31:0] p);
    if (v.kind == 2'd2) return (v.a + v.im) & 32'hFFFF_FFFE;
    return p + (v.im & 32'hFFFF_FFFE);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc, RV);
    rst_n = 1;
    @(negedge clk);
    check("R1 pc after release", pc, RV);
    exp_pc = RV;

    for (int i = 0; i < NV; i++) begin
      is_branch = VT[i].kind == 2'd0;
      is_jal    = VT[i].kind == 2'd1;
      is_jalr   = VT[i].kind == 2'd2;
      cond = VT[i].f3; rs1_val = VT[i].a; rs2_val = VT[i].b;
      imm = VT[i].im; rd_idx = VT[i].rd; step = 1;
      #1;
      check($sformatf("R2 R5 R6 R7 redirect v%0d", i), {31'd0, redirect}, {31'd0, VT[i].tk});
      check($sformatf("R9 misalign v%0d", i), {31'd0, misalign}, {31'd0, VT[i].ms});
      check($sformatf("R8 link_we v%0d", i), {31'd0, link_we}, {31'd0, VT[i].lw});
      check($sformatf("R8 link_val v%0d", i), link_val, exp_pc + 32'd4);
      if (VT[i].ms)      exp_pc = exp_pc;
      else if (VT[i].tk) exp_pc = tgt(VT[i], exp_pc);
      else               exp_pc = exp_pc + 32'd4;
      @(negedge clk);
      step = 0;
      check($sformatf("R3 R4 R9 pc v%0d", i), pc, exp_pc);
    end

    // R10: step low holds pc, outputs quiet even with a jump presented
    is_branch = 0; is_jal = 1; is_jalr = 0; imm = 32'h40; rd_idx = 5'd2; step = 0;
    #1;
    check("R10 idle redirect", {31'd0, redirect}, 32'd0);
    check("R10 idle link_we", {31'd0, link_we}, 32'd0);
    @(negedge clk); @(negedge clk);
    check("R10 idle pc hold", pc, exp_pc);

    // R11: jalr wins over jal and branch
    is_branch = 1; is_jal = 1; is_jalr = 1; cond = 3'b001;
    rs1_val = 32'h5000; rs2_val = 32'h5000; imm = 32'h8; step = 1;
    @(negedge clk); step = 0;
    check("R11 jalr priority", pc, 32'h5008);
    is_jalr = 0; imm = 32'h20; step = 1;
    @(negedge clk); step = 0;
    check("R11 jal over not-taken branch", pc, 32'h5028);

    // R1: reset mid-run returns to the vector
    is_branch = 0; is_jal = 0; rst_n = 0;
    @(negedge clk);
    check("R1 reset mid-run", pc, RV);
    rst_n = 1;
    step = 1;
    @(negedge clk); step = 0;
    check("R4 sequential after reset", pc, RV + 32'd4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule